// File: doc/BRIEF.md
# Three-Share Field Interpolation Secret Recovery

This block recovers a secret word that was split among shareholders as the top-degree coefficient of a quadratic over GF(2^W). It takes three shareholder identifiers and their three share values. It returns the coefficient of the squared term of the unique polynomial through those three points. Field addition is bitwise XOR. Each share is weighted by the inverse of the product of its identifier's XOR differences to the other two identifiers, and the weighted shares are XOR-summed.

A single full-width combinational field multiplier is shared across thirteen one-cycle steps under a step counter. The three weights need only one field inversion. The block first forms the three denominators and their common product, then inverts that product once with a bit-serial binary Euclid unit that runs for exactly 2W iterations. Each weight is then the common inverse times the other two denominators. The run length is fixed at 13 + 2W cycles whatever the operands. If identifiers collide, the run still completes on schedule and an error flag is raised.

Top module: `lagr_reconstruct`

## Requirements
- R1: With three distinct identifiers z0, z1, z2 and shares s0, s1, s2, `secret_o` at completion equals s0·(z0^z1)⁻¹(z0^z2)⁻¹ ^ s1·(z1^z0)⁻¹(z1^z2)⁻¹ ^ s2·(z2^z0)⁻¹(z2^z1)⁻¹. All products are polynomial products reduced modulo x^W + POLY, where `POLY` holds the low W coefficients.
- R2: `done_o` rises exactly 13 + 2W clock edges after the edge that accepted `start_i`, and at no other time during the run.
- R3: `done_o` is high for exactly one cycle per accepted start.
- R4: If any two identifiers are equal, completion still occurs at the R2 latency with `err_o` = 1 and `secret_o` = 0.
- R5: With three distinct identifiers, `err_o` = 0 at completion.
- R6: `start_i` asserted while a run is in progress is ignored. The running result is unaffected, and no extra completion follows.
- R7: `secret_o` and `err_o` change only on the edge that raises `done_o`, and hold their values until the next completion.
- R8: After synchronous reset, `secret_o` = 0, `err_o` = 0 and `done_o` = 0.
- R9: The result does not depend on the order in which the three (identifier, share) pairs are presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a recovery; sampled only when idle |
| id0_i | input | W | Identifier of first shareholder |
| id1_i | input | W | Identifier of second shareholder |
| id2_i | input | W | Identifier of third shareholder |
| share0_i | input | W | Share of first shareholder |
| share1_i | input | W | Share of second shareholder |
| share2_i | input | W | Share of third shareholder |
| secret_o | output | W | Recovered coefficient, held between completions |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Identifier collision seen in the last run |

## Verification
The bench uses a 4-bit field and sweeps every ordered triple of identifiers, so all collision patterns are covered: pairs, full triples and zero identifiers. A weight mixed up between shares, or a wrong reduction, shows as a wrong coefficient. A missed collision shows as a spurious nonzero secret with the flag low. One inverter iteration too many or too few shows as a corrupted inverse. The bench also fires a second start mid-run. A design that restarted would complete late with the second operand set's answer, and one that queued the request would pulse done a second time. Reordered shareholder pairs catch a weight bound to a position instead of to its identifier.

// File: rtl/lagr_pkg.sv
package lagr_pkg;

    // One operation per active cycle; the encoding follows the schedule order.
    typedef enum logic [3:0] {
        OP_NONE = 4'd0,
        OP_D0   = 4'd1,   // (z0^z1)(z0^z2)
        OP_D1   = 4'd2,   // (z0^z1)(z1^z2)
        OP_D2   = 4'd3,   // (z0^z2)(z1^z2)
        OP_T    = 4'd4,   // d0*d1
        OP_DD   = 4'd5,   // t*d2 : full denominator product
        OP_E12  = 4'd6,   // d1*d2
        OP_E02  = 4'd7,   // d0*d2, inverter load
        OP_INV  = 4'd8,   // one inverter iteration
        OP_C0   = 4'd9,
        OP_P0   = 4'd10,
        OP_C1   = 4'd11,
        OP_P1   = 4'd12,
        OP_C2   = 4'd13,
        OP_P2   = 4'd14   // last step, completion
    } lagr_op_e;

    localparam int LAGR_PRE_STEPS  = 7;
    localparam int LAGR_POST_STEPS = 6;

    function automatic int lagr_latency(input int w);
        return LAGR_PRE_STEPS + LAGR_POST_STEPS + 2 * w;
    endfunction

    function automatic int lagr_cnt_bits(input int w);
        return $clog2(lagr_latency(w) + 1);
    endfunction

endpackage

// File: rtl/lagr_gf_mul.sv
module lagr_gf_mul #(
    parameter int             W    = 128,
    parameter logic [W-1:0]   POLY = W'('h87)
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] p_o
);
    // Horner chain, multiplier bits from the top down, reduced at every stage.
    logic [W-1:0] part [W+1];
    assign part[0] = '0;

    for (genvar g = 0; g < W; g++) begin : g_stage
        assign part[g+1] = {part[g][W-2:0], 1'b0}
                         ^ ({W{part[g][W-1]}} & POLY)
                         ^ ({W{b_i[W-1-g]}} & a_i);
    end

    assign p_o = part[W];
endmodule

// File: rtl/lagr_gf_inv.sv
module lagr_gf_inv #(
    parameter int             W    = 128,
    parameter logic [W-1:0]   POLY = W'('h87)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic         step_i,
    input  logic [W-1:0] val_i,
    output logic [W-1:0] inv_o
);
    localparam int         DW    = $clog2(2 * W + 2) + 1;
    localparam logic [W:0] PFULL = {1'b1, POLY};

    logic [W:0]    r_q, s_q;
    logic [W-1:0]  u_q, v_q;
    logic [DW-1:0] dl_q;

    function automatic logic [W-1:0] times_x(input logic [W-1:0] v);
        return {v[W-2:0], 1'b0} ^ ({W{v[W-1]}} & POLY);
    endfunction

    function automatic logic [W-1:0] over_x(input logic [W-1:0] v);
        return v[0] ? ({1'b1, v[W-1:1]} ^ {1'b0, POLY[W-1:1]})
                    : {1'b0, v[W-1:1]};
    endfunction

    logic [W:0]   s_sub, s_shl;
    logic [W-1:0] v_sub;

    always_comb begin
        s_sub = s_q[W] ? (s_q ^ r_q) : s_q;
        v_sub = s_q[W] ? (v_q ^ u_q) : v_q;
        s_shl = {s_sub[W-1:0], 1'b0};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q  <= '0;
            s_q  <= '0;
            u_q  <= '0;
            v_q  <= '0;
            dl_q <= '0;
        end else if (load_i) begin
            r_q  <= {1'b0, val_i};
            s_q  <= PFULL;
            u_q  <= W'(1);
            v_q  <= '0;
            dl_q <= '0;
        end else if (step_i) begin
            if (!r_q[W]) begin
                r_q  <= {r_q[W-1:0], 1'b0};
                u_q  <= times_x(u_q);
                dl_q <= dl_q + 1'b1;
            end else if (dl_q == '0) begin
                r_q  <= s_shl;
                s_q  <= r_q;
                u_q  <= times_x(v_sub);
                v_q  <= u_q;
                dl_q <= DW'(1);
            end else begin
                s_q  <= s_shl;
                v_q  <= v_sub;
                u_q  <= over_x(u_q);
                dl_q <= dl_q - 1'b1;
            end
        end
    end

    assign inv_o = u_q;
endmodule

// File: rtl/lagr_ctrl.sv
module lagr_ctrl
    import lagr_pkg::*;
#(
    parameter int W = 128
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start_i,
    output logic     take_o,
    output lagr_op_e op_o
);
    localparam int            LAT  = lagr_latency(W);
    localparam int            CW   = lagr_cnt_bits(W);
    localparam logic [CW-1:0] PRE  = CW'(LAGR_PRE_STEPS);
    localparam logic [CW-1:0] INVE = CW'(LAGR_PRE_STEPS + 2 * W);
    localparam logic [CW-1:0] OFS  = CW'(2 * W - 1);
    localparam logic [CW-1:0] LAST = CW'(LAT);

    logic [CW-1:0] cnt_q;

    assign take_o = start_i && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst)                 cnt_q <= '0;
        else if (take_o)         cnt_q <= CW'(1);
        else if (cnt_q == LAST)  cnt_q <= '0;
        else if (cnt_q != '0)    cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        if (cnt_q == '0)        op_o = OP_NONE;
        else if (cnt_q <= PRE)  op_o = lagr_op_e'(4'(cnt_q));
        else if (cnt_q <= INVE) op_o = OP_INV;
        else                    op_o = lagr_op_e'(4'(cnt_q - OFS));
    end
endmodule

// File: rtl/lagr_reconstruct.sv
module lagr_reconstruct
    import lagr_pkg::*;
#(
    parameter int             W    = 128,
    parameter logic [W-1:0]   POLY = W'('h87)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic [W-1:0] id0_i,
    input  logic [W-1:0] id1_i,
    input  logic [W-1:0] id2_i,
    input  logic [W-1:0] share0_i,
    input  logic [W-1:0] share1_i,
    input  logic [W-1:0] share2_i,
    output logic [W-1:0] secret_o,
    output logic         done_o,
    output logic         err_o
);
    typedef struct packed {
        logic [W-1:0] z0, z1, z2;
        logic [W-1:0] s0, s1, s2;
    } job_t;

    job_t         job_q;
    logic         take;
    lagr_op_e     op;
    logic [W-1:0] dif01, dif02, dif12;
    logic         dup;
    logic [W-1:0] d0_q, d1_q, d2_q, t_q, dd_q, e12_q, e02_q, cw_q, acc_q;
    logic [W-1:0] ma, mb, prod, dinv;

    lagr_ctrl #(.W(W)) u_ctrl (
        .clk(clk), .rst(rst), .start_i(start_i), .take_o(take), .op_o(op)
    );

    lagr_gf_mul #(.W(W), .POLY(POLY)) u_mul (.a_i(ma), .b_i(mb), .p_o(prod));

    lagr_gf_inv #(.W(W), .POLY(POLY)) u_inv (
        .clk(clk), .rst(rst),
        .load_i(op == OP_E02), .step_i(op == OP_INV),
        .val_i(dd_q), .inv_o(dinv)
    );

    assign dif01 = job_q.z0 ^ job_q.z1;
    assign dif02 = job_q.z0 ^ job_q.z2;
    assign dif12 = job_q.z1 ^ job_q.z2;
    assign dup   = (dif01 == '0) || (dif02 == '0) || (dif12 == '0);

    always_comb begin
        unique case (op)
            OP_D0:   begin ma = dif01;    mb = dif02; end
            OP_D1:   begin ma = dif01;    mb = dif12; end
            OP_D2:   begin ma = dif02;    mb = dif12; end
            OP_T:    begin ma = d0_q;     mb = d1_q;  end
            OP_DD:   begin ma = t_q;      mb = d2_q;  end
            OP_E12:  begin ma = d1_q;     mb = d2_q;  end
            OP_E02:  begin ma = d0_q;     mb = d2_q;  end
            OP_C0:   begin ma = dinv;     mb = e12_q; end
            OP_P0:   begin ma = job_q.s0; mb = cw_q;  end
            OP_C1:   begin ma = dinv;     mb = e02_q; end
            OP_P1:   begin ma = job_q.s1; mb = cw_q;  end
            OP_C2:   begin ma = dinv;     mb = t_q;   end
            OP_P2:   begin ma = job_q.s2; mb = cw_q;  end
            default: begin ma = '0;       mb = '0;    end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            job_q    <= '0;
            {d0_q, d1_q, d2_q, t_q, dd_q} <= '0;
            {e12_q, e02_q, cw_q, acc_q}   <= '0;
            secret_o <= '0;
            err_o    <= 1'b0;
            done_o   <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (take) job_q <= '{z0: id0_i, z1: id1_i, z2: id2_i,
                                 s0: share0_i, s1: share1_i, s2: share2_i};
            unique case (op)
                OP_D0:  d0_q  <= prod;
                OP_D1:  d1_q  <= prod;
                OP_D2:  d2_q  <= prod;
                OP_T:   t_q   <= prod;
                OP_DD:  dd_q  <= prod;
                OP_E12: e12_q <= prod;
                OP_E02: e02_q <= prod;
                OP_C0, OP_C1, OP_C2: cw_q <= prod;
                OP_P0:  acc_q <= prod;
                OP_P1:  acc_q <= acc_q ^ prod;
                OP_P2: begin
                    secret_o <= dup ? '0 : (acc_q ^ prod);
                    err_o    <= dup;
                    done_o   <= 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/lagr_reconstruct_chk.sv
module lagr_reconstruct_chk
    import lagr_pkg::*;
#(
    parameter int W = 128
) (
    input logic         clk,
    input logic         rst,
    input logic         start_i,
    input logic [W-1:0] id0_i,
    input logic [W-1:0] id1_i,
    input logic [W-1:0] id2_i,
    input logic [W-1:0] secret_o,
    input logic         done_o,
    input logic         err_o
);
    localparam int            CW  = lagr_cnt_bits(W);
    localparam logic [CW-1:0] LAT = CW'(lagr_latency(W));

    logic          ck_busy;
    logic [CW-1:0] ck_cnt;
    logic          ck_dup;
    logic          in_dup;

    assign in_dup = (id0_i == id1_i) || (id0_i == id2_i) || (id1_i == id2_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            ck_busy <= 1'b0;
            ck_cnt  <= '0;
            ck_dup  <= 1'b0;
        end else if (start_i && (!ck_busy || ck_cnt == LAT)) begin
            ck_busy <= 1'b1;
            ck_cnt  <= '0;
            ck_dup  <= in_dup;
        end else if (ck_busy) begin
            if (ck_cnt == LAT) ck_busy <= 1'b0;
            else               ck_cnt  <= ck_cnt + 1'b1;
        end
    end

    a_r2_done_on_time: assert property (@(posedge clk) disable iff (rst)
        (ck_busy && ck_cnt == LAT) |-> done_o);

    a_r2_no_stray_done: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (ck_busy && ck_cnt == LAT));

    a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    a_r4_flag_matches_ids: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (err_o == ck_dup));

    a_r4_zero_on_collision: assert property (@(posedge clk) disable iff (rst)
        (done_o && err_o) |-> (secret_o == '0));

    a_r7_hold_outputs: assert property (@(posedge clk) disable iff (rst)
        ($changed(secret_o) || $changed(err_o)) |-> done_o);
endmodule

bind lagr_reconstruct lagr_reconstruct_chk #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .start_i(start_i),
    .id0_i(id0_i), .id1_i(id1_i), .id2_i(id2_i),
    .secret_o(secret_o), .done_o(done_o), .err_o(err_o)
);

// File: tb/tb_lagr_reconstruct.sv
module tb_lagr_reconstruct;
    localparam int           W   = 4;
    localparam logic [W-1:0] P   = 4'h3;   // x^4 + x + 1
    localparam int           LAT = 13 + 2 * W;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [W-1:0] z0 = '0, z1 = '0, z2 = '0, s0 = '0, s1 = '0, s2 = '0;
    logic [W-1:0] secret;
    logic         done, err;

    int errs = 0;
    int checks = 0;

    always #2.5ns clk = ~clk;

    lagr_reconstruct #(.W(W), .POLY(P)) dut (
        .clk(clk), .rst(rst), .start_i(start),
        .id0_i(z0), .id1_i(z1), .id2_i(z2),
        .share0_i(s0), .share1_i(s1), .share2_i(s2),
        .secret_o(secret), .done_o(done), .err_o(err)
    );

    function automatic logic [W-1:0] gmul(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] r = '0;
        logic [W-1:0] aa = a;
        for (int i = 0; i < W; i++) begin
            if (b[i]) r ^= aa;
            aa = {aa[W-2:0], 1'b0} ^ (aa[W-1] ? P : '0);
        end
        return r;
    endfunction

    function automatic logic [W-1:0] ginv(input logic [W-1:0] a);
        for (int c = 1; c < (1 << W); c++)
            if (gmul(a, W'(c)) == W'(1)) return W'(c);
        return '0;
    endfunction

    task automatic model(input logic [W-1:0] a, b, c, x, y, w,
                         output logic [W-1:0] sec, output bit dup);
        logic [W-1:0] ab, ac, bc;
        ab = a ^ b; ac = a ^ c; bc = b ^ c;
        dup = (ab == '0) || (ac == '0) || (bc == '0);
        if (dup) sec = '0;
        else sec = gmul(x, ginv(gmul(ab, ac))) ^ gmul(y, ginv(gmul(ab, bc)))
                 ^ gmul(w, ginv(gmul(ac, bc)));
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [W-1:0] a, b, c, x, y, w);
        z0 = a; z1 = b; z2 = c; s0 = x; s1 = y; s2 = w;
    endtask

    // Launch one run and wait for completion; returns edges from accept to done.
    task automatic run(input logic [W-1:0] a, b, c, x, y, w, output int lat);
        @(negedge clk);
        drive(a, b, c, x, y, w);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < LAT + 10) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic full_check(input logic [W-1:0] a, b, c, x, y, w);
        int lat;
        logic [W-1:0] exp_s;
        bit exp_d;
        model(a, b, c, x, y, w, exp_s, exp_d);
        run(a, b, c, x, y, w, lat);
        check(lat == LAT, exp_d ? "R4" : "R2", "latency", lat, LAT);
        if (exp_d) begin
            check(err == 1'b1, "R4", "err on collision", int'(err), 1);
            check(secret == '0, "R4", "secret on collision", int'(secret), 0);
        end else begin
            check(err == 1'b0, "R5", "err with distinct ids", int'(err), 0);
            check(secret == exp_s, "R1", "secret value", int'(secret), int'(exp_s));
        end
        @(negedge clk);
        check(done == 1'b0, "R3", "done width", int'(done), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        int lat;
        logic [W-1:0] exp_s, first;
        bit exp_d;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(secret == '0, "R8", "secret after reset", int'(secret), 0);
        check(err == 1'b0, "R8", "err after reset", int'(err), 0);
        check(done == 1'b0, "R8", "done after reset", int'(done), 0);

        // Exhaustive sweep of identifier triples: R1 R2 R3 R4 R5
        for (int i = 0; i < 4096; i++) begin
            full_check(W'(i), W'(i >> 4), W'(i >> 8),
                       W'(i * 7 + 3), W'(i * 5 + 1), W'(i * 3 + 9));
        end

        // R9: every ordering of the same three pairs gives one answer
        model(4'h2, 4'h9, 4'hE, 4'h5, 4'hC, 4'h7, exp_s, exp_d);
        run(4'h2, 4'h9, 4'hE, 4'h5, 4'hC, 4'h7, lat);
        first = secret;
        run(4'hE, 4'h2, 4'h9, 4'h7, 4'h5, 4'hC, lat);
        check(secret == first, "R9", "rotated order", int'(secret), int'(first));
        run(4'h9, 4'hE, 4'h2, 4'hC, 4'h7, 4'h5, lat);
        check(secret == first, "R9", "rotated order again", int'(secret), int'(first));
        run(4'h9, 4'h2, 4'hE, 4'hC, 4'h5, 4'h7, lat);
        check(secret == exp_s, "R9", "swapped order", int'(secret), int'(exp_s));

        // R6 and R7: second start mid-run is dropped, outputs hold meanwhile
        first = secret;
        model(4'h1, 4'h6, 4'hB, 4'h3, 4'hA, 4'hF, exp_s, exp_d);
        @(negedge clk);
        drive(4'h1, 4'h6, 4'hB, 4'h3, 4'hA, 4'hF);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < LAT + 10) begin
            @(negedge clk);
            lat++;
            if (lat == 5) begin
                check(secret == first, "R7", "secret held mid-run", int'(secret), int'(first));
                check(err == 1'b0, "R7", "err held mid-run", int'(err), 0);
                drive(4'h4, 4'h4, 4'h8, 4'h1, 4'h2, 4'h3);
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
        end
        check(lat == LAT, "R6", "latency from first start", lat, LAT);
        check(secret == exp_s, "R6", "first operands kept", int'(secret), int'(exp_s));
        check(err == 1'b0, "R6", "second operands not used", int'(err), 0);
        for (int k = 0; k < LAT + 4; k++) begin
            @(negedge clk);
            if (done) check(1'b0, "R6", "extra completion", 1, 0);
        end
        check(secret == exp_s, "R7", "secret held after run", int'(secret), int'(exp_s));

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule